// File: doc/BRIEF.md
# Packed Lane Variable Shifter

This block shifts the lanes of a 64-bit packed operand. Each lane gets its own shift count. The first operand is split into four 16-bit lanes or two 32-bit lanes. Each lane is shifted by a count taken from the lane in the same position of the second operand. Four shift kinds are supported: logical left, logical right, arithmetic right, and a saturating left shift. The saturating shift clamps to the signed lane range instead of dropping the bits that overflow.

A 9-bit operation code selects the lane width and the shift kind. A code outside the eight defined values gives a zero result and raises an illegal flag. With the default configuration, the result and the flag are registered and appear one cycle after an input strobe, together with an output valid pulse. An execution pipeline uses the block as one of its functional units.

Top module: `simd_shift_unit`

## Requirements
- R1: Lanes are processed independently. Code bit 2 clear selects four 16-bit lanes at bit offsets 0, 16, 32 and 48. Code bit 2 set selects two 32-bit lanes at offsets 0 and 32.
- R2: The count for a lane comes from the low bits of the matching lane of `src_b`: 4 bits for 16-bit lanes and 5 bits for 32-bit lanes. All higher bits of that lane are ignored.
- R3: Logical left shift fills the vacated low bits with zeros and discards the bits shifted out of the lane.
- R4: Logical right shift fills the vacated high bits with zeros.
- R5: Arithmetic right shift fills the vacated high bits with copies of the lane sign bit.
- R6: Saturating left shift treats the lane as signed and gives the exact shifted value when it fits. A positive overflow gives 0x7FFF or 0x7FFFFFFF. A negative overflow gives 0x8000 or 0x80000000.
- R7: The legal codes are as follows. For 16-bit lanes: 0x021 logical left, 0x023 logical right, 0x029 saturating left, 0x02B arithmetic right. For 32-bit lanes: 0x025, 0x027, 0x02D and 0x02F, in the same kind order. Code bits {3,1} encode the kind: 00 logical left, 01 logical right, 10 saturating left, 11 arithmetic right.
- R8: Any other code gives a result of zero with `illegal_op` high. A legal code gives `illegal_op` low.
- R9: A lane whose count is zero passes through unchanged in every mode, including saturating mode.
- R10: When `in_valid` is high at a rising edge, `result` and `illegal_op` hold the outcome of that operation from the next cycle on, and `out_valid` is high for exactly that cycle. Without a strobe, `out_valid` is low and `result` keeps its value.
- R11: While `rst` is high, `out_valid`, `result` and `illegal_op` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 9 | Operation code |
| src_a | input | 64 | Packed lanes to shift |
| src_b | input | 64 | Packed per-lane shift counts |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Packed shifted lanes |
| illegal_op | output | 1 | Code was not one of the eight defined values |

## Verification
The bench targets the signed extremes 0x8000, 0x7FFF, 0x80000000 and 0x7FFFFFFF at every count in all eight modes. A clamp that tests only the sign of the result, or that works at lane precision, would return a wrapped value there instead of the saturated one. A count field that reads one bit too many or too few is exposed by counts with high bits set. A sign fill that leaks into the next lane is exposed by mixed-sign lanes with different counts. Illegal codes next to the legal ones and zero counts in saturating mode catch a loose decoder and a clamp that trips on unshifted values.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

    typedef enum logic [1:0] {
        SH_LL  = 2'b00,
        SH_RL  = 2'b01,
        SH_LAS = 2'b10,
        SH_RA  = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic        legal;
        logic        wide;
        shift_kind_e kind;
    } shift_ctrl_t;

    localparam int OP_W = 9;
    localparam logic [4:0] OP_GROUP = 5'b00010;

    // Group in bits 8..4, bit 0 set; bit 2 = wide lanes; bits {3,1} = kind
    function automatic shift_ctrl_t decode_op(input logic [OP_W-1:0] op);
        shift_ctrl_t c;
        c.legal = (op[8:4] == OP_GROUP) && op[0];
        c.wide  = op[2];
        c.kind  = shift_kind_e'({op[3], op[1]});
        return c;
    endfunction

endpackage

// File: rtl/shift_op_decode.sv
module shift_op_decode
    import simd_shift_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output shift_ctrl_t     ctrl
);
    always_comb ctrl = decode_op(op_code);
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
    import simd_shift_pkg::*;
#(
    parameter int LANE_W = 16,
    localparam int CNT_W = $clog2(LANE_W)
) (
    input  logic [LANE_W-1:0] lane_in,
    input  logic [CNT_W-1:0]  cnt,
    input  shift_kind_e       kind,
    output logic [LANE_W-1:0] lane_out
);
    logic signed [2*LANE_W-1:0] ext;
    logic signed [2*LANE_W-1:0] prod;
    logic                       ovf;
    logic [LANE_W-1:0]          sat;

    always_comb begin
        ext  = {{LANE_W{lane_in[LANE_W-1]}}, lane_in};
        prod = ext <<< cnt;
        // upper half plus lane sign bit must be a pure sign extension
        ovf  = (prod[2*LANE_W-1:LANE_W-1] != {(LANE_W+1){prod[2*LANE_W-1]}});
        sat  = lane_in[LANE_W-1] ? {1'b1, {(LANE_W-1){1'b0}}}
                                 : {1'b0, {(LANE_W-1){1'b1}}};
        unique case (kind)
            SH_LL:   lane_out = lane_in << cnt;
            SH_RL:   lane_out = lane_in >> cnt;
            SH_RA:   lane_out = $signed(lane_in) >>> cnt;
            SH_LAS:  lane_out = ovf ? sat : prod[LANE_W-1:0];
            default: lane_out = '0;
        endcase
    end
endmodule

// File: rtl/shift_lane_bank.sv
module shift_lane_bank
    import simd_shift_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16,
    localparam int LANES = DATA_W / LANE_W,
    localparam int CNT_W = $clog2(LANE_W)
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] bank_out
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_shifter #(.LANE_W(LANE_W)) u_lane (
            .lane_in (src_a[i*LANE_W +: LANE_W]),
            .cnt     (src_b[i*LANE_W +: CNT_W]),
            .kind    (kind),
            .lane_out(bank_out[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
    import simd_shift_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal_op
);
    shift_ctrl_t       ctrl;
    logic [DATA_W-1:0] narrow_out;
    logic [DATA_W-1:0] wide_out;
    logic [DATA_W-1:0] comb_res;

    shift_op_decode u_dec (.op_code(op_code), .ctrl(ctrl));

    shift_lane_bank #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) u_narrow (
        .src_a(src_a), .src_b(src_b), .kind(ctrl.kind), .bank_out(narrow_out)
    );

    shift_lane_bank #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) u_wide (
        .src_a(src_a), .src_b(src_b), .kind(ctrl.kind), .bank_out(wide_out)
    );

    always_comb begin
        if (!ctrl.legal)    comb_res = '0;
        else if (ctrl.wide) comb_res = wide_out;
        else                comb_res = narrow_out;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid  <= 1'b0;
                result     <= '0;
                illegal_op <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    result     <= comb_res;
                    illegal_op <= !ctrl.legal;
                end
            end
        end
    end else begin : g_comb
        always_comb begin
            out_valid  = in_valid;
            result     = comb_res;
            illegal_op = !ctrl.legal;
        end
    end
endmodule

// File: rtl/simd_shift_chk.sv
module simd_shift_chk #(
    parameter int DATA_W  = 64,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [8:0]        op_code,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              illegal_op
);
    logic code_ok;
    always_comb code_ok = (op_code[8:4] == 5'b00010) && op_code[0];

    if (OUT_REG) begin : g_props
        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid); // R10
        AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid); // R10
        AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(result) && $stable(illegal_op)); // R10
        AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !code_ok) |=> (illegal_op && result == '0)); // R8
        AST_LEGAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (in_valid && code_ok) |=> !illegal_op); // R8
        AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (rst)
            (in_valid && code_ok && src_b == '0) |=> result == $past(src_a)); // R9
        AST_RESET_QUIET: assert property (@(posedge clk)
            rst |=> (!out_valid && result == '0 && !illegal_op)); // R11
    end
endmodule

bind simd_shift_unit simd_shift_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .result(result), .illegal_op(illegal_op)
);

// File: tb/simd_shift_unit_tb.sv
module simd_shift_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [8:0]  op_code = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal_op;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    simd_shift_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .result(result), .illegal_op(illegal_op)
    );

    logic [8:0] legal_ops [8] = '{9'h021, 9'h023, 9'h029, 9'h02B,
                                  9'h025, 9'h027, 9'h02D, 9'h02F};

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural model: explicit code table, integer arithmetic per lane
    function automatic logic [63:0] model(input logic [8:0] op, input logic [63:0] a,
                                          input logic [63:0] b, output bit ill);
        int w; int kind; longint unsigned mask; logic [63:0] r;
        ill = 0; r = '0; w = 16; kind = 0;
        case (op)
            9'h021: begin w = 16; kind = 0; end
            9'h023: begin w = 16; kind = 1; end
            9'h029: begin w = 16; kind = 2; end
            9'h02B: begin w = 16; kind = 3; end
            9'h025: begin w = 32; kind = 0; end
            9'h027: begin w = 32; kind = 1; end
            9'h02D: begin w = 32; kind = 2; end
            9'h02F: begin w = 32; kind = 3; end
            default: ill = 1;
        endcase
        if (ill) return '0;
        mask = (64'd1 << w) - 1;
        for (int l = 0; l < 64 / w; l++) begin
            longint unsigned v; longint sv; longint t; int c;
            v = (a >> (l * w)) & mask;
            c = int'((b >> (l * w)) % longint'(w));
            sv = (v >= (64'd1 << (w - 1))) ? longint'(v) - longint'(64'd1 << w) : longint'(v);
            case (kind)
                0: t = longint'((v << c) & mask);
                1: t = longint'(v >> c);
                3: t = sv >>> c;
                default: begin
                    t = sv * (longint'(1) << c);
                    if (t > (longint'(1) << (w - 1)) - 1) t = (longint'(1) << (w - 1)) - 1;
                    if (t < -(longint'(1) << (w - 1))) t = -(longint'(1) << (w - 1));
                end
            endcase
            r = r | ((64'(t) & mask) << (l * w));
        end
        return r;
    endfunction

    function automatic string kind_tag(input logic [8:0] op);
        case (op)
            9'h021, 9'h025: return "R3";
            9'h023, 9'h027: return "R4";
            9'h029, 9'h02D: return "R6";
            9'h02B, 9'h02F: return "R5";
            default:        return "R8";
        endcase
    endfunction

    // drive at negedge, result registered at next posedge, sample at next negedge
    task automatic run_op(input logic [8:0] op, input logic [63:0] a,
                          input logic [63:0] b, input string tag);
        logic [63:0] exp; bit ill;
        exp = model(op, a, b, ill);
        op_code = op; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(result == exp, tag, result, exp);
        check(illegal_op == ill, "R8", 64'(illegal_op), 64'(ill));
        check(out_valid == 1'b1, "R10", 64'(out_valid), 64'd1);
    endtask

    initial begin
        #(8 * 150000);
        failures++; checks++;
        $display("FAIL watchdog R10 actual=%h expected=%h", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check(out_valid == 0 && result == '0 && illegal_op == 0, "R11", result, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // directed lanes with distinct counts (R1, R7)
        run_op(9'h021, 64'h8001_4001_0003_1234, 64'h0003_0001_000F_0000, "R1");
        run_op(9'h02B, 64'h8000_7FFF_F000_0F00, 64'h0001_0002_0004_0008, "R1");
        run_op(9'h02F, 64'h8000_0000_7FFF_FFFF, 64'h0000_0004_0000_001F, "R7");
        run_op(9'h027, 64'h8000_0000_8000_0000, 64'h0000_001F_0000_0001, "R7");

        // count uses only low bits of each lane (R2)
        run_op(9'h023, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFF1_0012_8004_7FF8, "R2");
        run_op(9'h025, 64'h0000_0001_0000_0001, 64'hFFFF_FFE3_0000_0021, "R2");
        run_op(9'h029, 64'h0001_0001_0001_0001, 64'h0010_0020_FFF0_0011, "R2");

        // extremes at every count in every mode (R6 and kinds)
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 32; c++) begin
                logic [63:0] b;
                b = {16'(c), 16'(c), 16'(c), 16'(c)};
                if (legal_ops[k][2]) begin
                    run_op(legal_ops[k], 64'h8000_0000_7FFF_FFFF, b, kind_tag(legal_ops[k]));
                    run_op(legal_ops[k], 64'hFFFF_FFFF_0000_0001, b, kind_tag(legal_ops[k]));
                end else begin
                    run_op(legal_ops[k], 64'h8000_7FFF_8000_7FFF, b, kind_tag(legal_ops[k]));
                    run_op(legal_ops[k], 64'hFFFF_0001_C000_3FFF, b, kind_tag(legal_ops[k]));
                end
            end
        end

        // zero count passes through (R9)
        for (int k = 0; k < 8; k++) begin
            run_op(legal_ops[k], {$urandom, $urandom}, 64'd0, "R9");
            run_op(legal_ops[k], 64'h8000_7FFF_8000_0000, 64'd0, "R9");
        end

        // illegal codes, including neighbours of legal ones (R8)
        run_op(9'h020, 64'h1234_5678_9ABC_DEF0, 64'd1, "R8");
        run_op(9'h121, 64'h1234_5678_9ABC_DEF0, 64'd1, "R8");
        run_op(9'h031, 64'h1234_5678_9ABC_DEF0, 64'd1, "R8");
        run_op(9'h1FF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, "R8");
        run_op(9'h000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R8");

        // hold without strobe (R10)
        run_op(9'h025, 64'h0000_00FF_0000_0F0F, 64'h0000_0004_0000_0008, "R3");
        held = result;
        op_code = 9'h023; src_a = '1; src_b = 64'h1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", 64'(out_valid), 64'd0);
        check(result == held, "R10", result, held);

        // random mix, back-to-back strobes
        for (int n = 0; n < 3000; n++) begin
            logic [8:0] op;
            op = ($urandom % 10 == 0) ? 9'($urandom) : legal_ops[$urandom % 8];
            run_op(op, {$urandom, $urandom}, {$urandom, $urandom}, kind_tag(op));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule